// File: doc/BRIEF.md
# Program Counter Branch Unit

This block holds the program counter of a small processor whose instructions are between one and five bytes long and whose code space has 12-bit byte addresses. Every cycle in which the decoder asserts `step`, the unit loads the counter with the address of the next instruction. That address is one of four things: the address just past the current instruction, an absolute target, a signed 8-bit displacement applied to the fall-through address, or a skip forward over up to three following instructions. The decoder supplies the lengths of those following instructions.

Jumps, branches and skips can be unconditional. They can instead depend on one of the four ALU flags, in either polarity, or on a single selected bit of a 24-bit operand. Subroutine calls always use an absolute target and are never conditional. A call saves its return address on a four-entry stack, and a return takes the address back off that stack. User code begins at byte address 48, which is the reset value of the counter. A return on an empty stack also lands at 48. A call made while the stack is full leaves the stack as it is and raises a sticky error.

The counter is held in a register inside the unit. The combinational `next_pc` and `taken` outputs show the result of the inputs currently presented, so the fetch logic can use that value in the same cycle.

Top module: `pc_branch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_q` becomes 48, the return stack empties and `stk_err` clears.
- R2: When `kind` is 0 (sequential), or one of the unused codes 6 and 7, `next_pc` equals `pc_q + cur_len` modulo 4096 and `taken` is 0. The field `cur_len` holds a byte length from 1 to 5.
- R3: When `kind` is 1 (jump) and the condition holds, `next_pc` equals `target`.
- R4: When `kind` is 2 (branch) and the condition holds, `next_pc` equals `pc_q + cur_len` plus the sign-extended `offset` (-128 to +127), modulo 4096.
- R5: When `kind` is 3 (skip) and the condition holds, `next_pc` equals `pc_q + cur_len` plus the lengths of the first `skip_n` following instructions, modulo 4096. Bits [2:0] of `skip_lens` give the length of the first following instruction, [5:3] the second and [8:6] the third. `skip_n` ranges from 0 to 3.
- R6: The codes of `cond` are: 0 always, 1 carry set, 2 carry clear, 3 zero, 4 nonzero, 5 negative, 6 positive (sign clear), 7 overflow set, 8 overflow clear. The bits of `flags` are [3] carry, [2] zero result, [1] negative, [0] overflow. Codes 11 to 15 never hold.
- R7: Code 9 of `cond` holds when bit `bit_sel` of `operand` is 1, and code 10 holds when that bit is 0. A `bit_sel` of 24 or above reads as 0.
- R8: A jump, branch or skip whose condition fails gives `next_pc = pc_q + cur_len` and `taken` = 0. When the condition holds, `taken` is 1.
- R9: When `kind` is 4 (call), `next_pc` equals `target` and `taken` is 1 whatever `cond` and `flags` are. On the step, `pc_q + cur_len` is pushed.
- R10: When `kind` is 5 (return), `next_pc` is the most recently pushed address that has not yet been popped, and the step removes it from the stack.
- R11: A return with an empty stack gives `next_pc` = 48.
- R12: A call made while four addresses are already stacked still jumps. It leaves the stacked addresses unchanged and sets `stk_err`, which stays set until reset.
- R13: On a clock edge with `step` low, `pc_q`, the stack and `stk_err` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Load `next_pc` into the counter and apply any stack operation |
| kind | input | 3 | Transfer kind (0 seq, 1 jump, 2 branch, 3 skip, 4 call, 5 return) |
| cond | input | 4 | Condition selector |
| flags | input | 4 | Carry, zero, negative, overflow |
| operand | input | 24 | Operand for the bit-test conditions |
| bit_sel | input | 5 | Index of the tested operand bit |
| target | input | 12 | Absolute target address |
| offset | input | 8 | Signed branch displacement |
| cur_len | input | 3 | Byte length of the current instruction |
| skip_n | input | 2 | Number of following instructions to skip |
| skip_lens | input | 9 | Byte lengths of the three following instructions |
| pc_q | output | 12 | Current program counter |
| next_pc | output | 12 | Address that the next step loads |
| taken | output | 1 | The current transfer is taken |
| stk_err | output | 1 | Sticky return-stack overflow |

## Verification
The bench aims at the address-wrap corners. It branches backwards past address 0 and forwards past 4095; a unit that failed to sign-extend the offset, or that added it to the current instruction's address instead of the fall-through address, would land at the wrong target. It sweeps every flag condition against all sixteen flag patterns, and it tests operand bits 0, 23 and out-of-range indexes, so an inverted polarity or a wrong bit index appears as a wrong `taken`. It fills the return stack, pushes once more and then drains it. A design that overwrote an entry on overflow would return to the wrong address, and one that wrapped on underflow would not return to 48.

// File: rtl/pcbr_pkg.sv
package pcbr_pkg;

    localparam int PC_W_DEF     = 12;
    localparam int OFS_W_DEF    = 8;
    localparam int OPND_W_DEF   = 24;
    localparam int BSEL_W_DEF   = 5;
    localparam int LEN_W_DEF    = 3;
    localparam int SKIP_MAX_DEF = 3;
    localparam int STK_DEF      = 4;
    localparam int USER_BASE    = 48;

    typedef enum logic [2:0] {
        XF_SEQ    = 3'd0,
        XF_JUMP   = 3'd1,
        XF_BRANCH = 3'd2,
        XF_SKIP   = 3'd3,
        XF_CALL   = 3'd4,
        XF_RET    = 3'd5
    } xfer_e;

    typedef enum logic [3:0] {
        CC_ALWAYS  = 4'd0,
        CC_C_SET   = 4'd1,
        CC_C_CLR   = 4'd2,
        CC_ZERO    = 4'd3,
        CC_NONZERO = 4'd4,
        CC_NEG     = 4'd5,
        CC_POS     = 4'd6,
        CC_V_SET   = 4'd7,
        CC_V_CLR   = 4'd8,
        CC_BIT_SET = 4'd9,
        CC_BIT_CLR = 4'd10
    } cond_e;

    typedef struct packed {
        logic carry;
        logic zero;
        logic neg;
        logic ovf;
    } flags_t;

    // Flag-only part of the condition decode; bit tests are resolved by the caller.
    function automatic logic flag_test(cond_e c, flags_t f);
        logic r;
        case (c)
            CC_ALWAYS:  r = 1'b1;
            CC_C_SET:   r = f.carry;
            CC_C_CLR:   r = !f.carry;
            CC_ZERO:    r = f.zero;
            CC_NONZERO: r = !f.zero;
            CC_NEG:     r = f.neg;
            CC_POS:     r = !f.neg;
            CC_V_SET:   r = f.ovf;
            CC_V_CLR:   r = !f.ovf;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pcbr_cond_eval.sv
module pcbr_cond_eval
    import pcbr_pkg::*;
#(
    parameter int OPND_W = OPND_W_DEF,
    parameter int BSEL_W = BSEL_W_DEF
) (
    input  logic [3:0]        cond,
    input  flags_t            flags,
    input  logic [OPND_W-1:0] operand,
    input  logic [BSEL_W-1:0] bit_sel,
    output logic              cond_ok
);

    localparam logic [BSEL_W:0] BIT_LIMIT = (BSEL_W+1)'(OPND_W);

    cond_e             sel;
    logic              in_range;
    logic [OPND_W-1:0] shifted;
    logic              bit_val;

    always_comb begin
        sel      = cond_e'(cond);
        in_range = ({1'b0, bit_sel} < BIT_LIMIT);
        shifted  = operand >> bit_sel;
        bit_val  = in_range && shifted[0];
        case (sel)
            CC_BIT_SET: cond_ok = bit_val;
            CC_BIT_CLR: cond_ok = !bit_val;
            default:    cond_ok = flag_test(sel, flags);
        endcase
    end

endmodule

// File: rtl/pcbr_target_gen.sv
module pcbr_target_gen #(
    parameter int PC_W     = 12,
    parameter int OFS_W    = 8,
    parameter int LEN_W    = 3,
    parameter int SKIP_MAX = 3,
    parameter int SKIP_W   = $clog2(SKIP_MAX + 1)
) (
    input  logic [PC_W-1:0]           pc,
    input  logic [LEN_W-1:0]          cur_len,
    input  logic [OFS_W-1:0]          offset,
    input  logic [SKIP_W-1:0]         skip_n,
    input  logic [SKIP_MAX*LEN_W-1:0] skip_lens,
    output logic [PC_W-1:0]           seq_pc,
    output logic [PC_W-1:0]           rel_pc,
    output logic [PC_W-1:0]           skip_pc
);

    logic [PC_W-1:0] psum [SKIP_MAX+1];

    assign seq_pc  = pc + {{(PC_W-LEN_W){1'b0}}, cur_len};
    assign rel_pc  = seq_pc + {{(PC_W-OFS_W){offset[OFS_W-1]}}, offset};
    assign psum[0] = seq_pc;

    // Running sum over the following instruction lengths, one adder per slot.
    for (genvar g = 0; g < SKIP_MAX; g++) begin : g_skip_sum
        assign psum[g+1] = psum[g] + {{(PC_W-LEN_W){1'b0}}, skip_lens[g*LEN_W +: LEN_W]};
    end

    always_comb begin
        skip_pc = psum[SKIP_MAX];
        for (int i = 0; i <= SKIP_MAX; i++) begin
            if (skip_n == SKIP_W'(i)) skip_pc = psum[i];
        end
    end

endmodule

// File: rtl/pcbr_ret_stack.sv
module pcbr_ret_stack #(
    parameter int PC_W  = 12,
    parameter int DEPTH = 4,
    parameter logic [PC_W-1:0] BASE = PC_W'(48)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    input  logic [PC_W-1:0] push_addr,
    output logic [PC_W-1:0] top_addr,
    output logic            overflow
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [PC_W-1:0]  mem_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_dec;
    logic             is_full;
    logic             is_empty;

    assign cnt_dec  = cnt_q - 1'b1;
    assign is_full  = (cnt_q == FULL);
    assign is_empty = (cnt_q == '0);
    assign top_addr = is_empty ? BASE : mem_q[cnt_dec[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            overflow <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= BASE;
        end else if (push) begin
            if (is_full) begin
                overflow <= 1'b1;
            end else begin
                mem_q[cnt_q[IDX_W-1:0]] <= push_addr;
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (pop && !is_empty) begin
            cnt_q <= cnt_dec;
        end
    end

    AST_STK_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);                                                     // R12
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);                                             // R12
    AST_FULL_PUSH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (push && is_full) |=> (is_full && overflow));                       // R12
    AST_PUSH_LIFO: assert property (@(posedge clk) disable iff (rst)
        (push && !is_full) |=> (top_addr == $past(push_addr)));            // R10
    AST_EMPTY_POP_BASE: assert property (@(posedge clk) disable iff (rst)
        (pop && is_empty) |=> is_empty);                                    // R11

endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
    import pcbr_pkg::*;
#(
    parameter int PC_W     = PC_W_DEF,
    parameter int OFS_W    = OFS_W_DEF,
    parameter int OPND_W   = OPND_W_DEF,
    parameter int BSEL_W   = BSEL_W_DEF,
    parameter int LEN_W    = LEN_W_DEF,
    parameter int SKIP_MAX = SKIP_MAX_DEF,
    parameter int STK_D    = STK_DEF,
    parameter int SKIP_W   = $clog2(SKIP_MAX + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      step,
    input  logic [2:0]                kind,
    input  logic [3:0]                cond,
    input  logic [3:0]                flags,
    input  logic [OPND_W-1:0]         operand,
    input  logic [BSEL_W-1:0]         bit_sel,
    input  logic [PC_W-1:0]           target,
    input  logic [OFS_W-1:0]          offset,
    input  logic [LEN_W-1:0]          cur_len,
    input  logic [SKIP_W-1:0]         skip_n,
    input  logic [SKIP_MAX*LEN_W-1:0] skip_lens,
    output logic [PC_W-1:0]           pc_q,
    output logic [PC_W-1:0]           next_pc,
    output logic                      taken,
    output logic                      stk_err
);

    localparam logic [PC_W-1:0] BASE_PC = PC_W'(USER_BASE);

    xfer_e           xk;
    logic            cond_ok;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] rel_pc;
    logic [PC_W-1:0] skip_pc;
    logic [PC_W-1:0] ret_pc;
    logic            do_push;
    logic            do_pop;

    assign xk = xfer_e'(kind);

    pcbr_cond_eval #(
        .OPND_W (OPND_W),
        .BSEL_W (BSEL_W)
    ) u_cond (
        .cond    (cond),
        .flags   (flags_t'(flags)),
        .operand (operand),
        .bit_sel (bit_sel),
        .cond_ok (cond_ok)
    );

    pcbr_target_gen #(
        .PC_W     (PC_W),
        .OFS_W    (OFS_W),
        .LEN_W    (LEN_W),
        .SKIP_MAX (SKIP_MAX),
        .SKIP_W   (SKIP_W)
    ) u_tgt (
        .pc        (pc_q),
        .cur_len   (cur_len),
        .offset    (offset),
        .skip_n    (skip_n),
        .skip_lens (skip_lens),
        .seq_pc    (seq_pc),
        .rel_pc    (rel_pc),
        .skip_pc   (skip_pc)
    );

    pcbr_ret_stack #(
        .PC_W  (PC_W),
        .DEPTH (STK_D),
        .BASE  (BASE_PC)
    ) u_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (do_push),
        .pop       (do_pop),
        .push_addr (seq_pc),
        .top_addr  (ret_pc),
        .overflow  (stk_err)
    );

    always_comb begin
        taken   = 1'b0;
        next_pc = seq_pc;
        do_push = 1'b0;
        do_pop  = 1'b0;
        case (xk)
            XF_JUMP: begin
                taken = cond_ok;
                if (cond_ok) next_pc = target;
            end
            XF_BRANCH: begin
                taken = cond_ok;
                if (cond_ok) next_pc = rel_pc;
            end
            XF_SKIP: begin
                taken = cond_ok;
                if (cond_ok) next_pc = skip_pc;
            end
            XF_CALL: begin
                taken   = 1'b1;
                next_pc = target;
                do_push = step;
            end
            XF_RET: begin
                taken   = 1'b1;
                next_pc = ret_pc;
                do_pop  = step;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       pc_q <= BASE_PC;
        else if (step) pc_q <= next_pc;
    end

    AST_RESET_BASE: assert property (@(posedge clk)
        rst |=> (pc_q == BASE_PC));                                         // R1
    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pc_q));                                           // R13
    AST_CALL_TARGET: assert property (@(posedge clk) disable iff (rst)
        (step && kind == 3'd4) |=> (pc_q == $past(target)));               // R9
    AST_NOT_TAKEN_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
        (step && !taken) |=>
        (pc_q == $past(pc_q) + {{(PC_W-LEN_W){1'b0}}, $past(cur_len)}));   // R8

endmodule

// File: tb/pc_branch_unit_tb.sv
module pc_branch_unit_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        step;
    logic [2:0]  kind;
    logic [3:0]  cond;
    logic [3:0]  flags;
    logic [23:0] operand;
    logic [4:0]  bit_sel;
    logic [11:0] target;
    logic [7:0]  offset;
    logic [2:0]  cur_len;
    logic [1:0]  skip_n;
    logic [8:0]  skip_lens;
    logic [11:0] pc_q;
    logic [11:0] next_pc;
    logic        taken;
    logic        stk_err;

    int checks   = 0;
    int failures = 0;

    int         m_pc;
    bit         m_err;
    int         m_stk[$];

    always #(CLK_P/2) clk = ~clk;

    pc_branch_unit dut_i (
        .clk(clk), .rst(rst), .step(step), .kind(kind), .cond(cond),
        .flags(flags), .operand(operand), .bit_sel(bit_sel), .target(target),
        .offset(offset), .cur_len(cur_len), .skip_n(skip_n),
        .skip_lens(skip_lens), .pc_q(pc_q), .next_pc(next_pc),
        .taken(taken), .stk_err(stk_err)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit cond_holds();
        bit b;
        b = (bit_sel < 24) ? operand[bit_sel] : 1'b0;
        case (cond)
            4'd0: return 1'b1;
            4'd1: return flags[3];
            4'd2: return !flags[3];
            4'd3: return flags[2];
            4'd4: return !flags[2];
            4'd5: return flags[1];
            4'd6: return !flags[1];
            4'd7: return flags[0];
            4'd8: return !flags[0];
            4'd9: return b;
            4'd10: return !b;
            default: return 1'b0;
        endcase
    endfunction

    // Reference next address and taken flag from the requirement text.
    task automatic model_next(output int nxt, output bit tk);
        int seq;
        int o;
        int s;
        seq = (m_pc + cur_len) % 4096;
        nxt = seq;
        tk  = 1'b0;
        case (kind)
            3'd1: begin tk = cond_holds(); if (tk) nxt = target; end
            3'd2: begin
                o  = (offset > 127) ? int'(offset) - 256 : int'(offset);
                tk = cond_holds();
                if (tk) nxt = (seq + o + 4096) % 4096;
            end
            3'd3: begin
                s = seq;
                for (int k = 0; k < skip_n; k++) s += skip_lens[k*3 +: 3];
                tk = cond_holds();
                if (tk) nxt = s % 4096;
            end
            3'd4: begin tk = 1'b1; nxt = target; end
            3'd5: begin tk = 1'b1; nxt = (m_stk.size() == 0) ? 48 : m_stk[$]; end
            default: ;
        endcase
    endtask

    task automatic cyc(string tag);
        int nxt;
        bit tk;
        int seq;
        model_next(nxt, tk);
        seq = (m_pc + cur_len) % 4096;
        #1;
        check(tag, next_pc, nxt);
        check(tag, taken, tk);
        @(posedge clk);
        if (step) begin
            if (kind == 3'd4) begin
                if (m_stk.size() == 4) m_err = 1'b1;
                else m_stk.push_back(seq);
            end else if (kind == 3'd5 && m_stk.size() > 0) begin
                void'(m_stk.pop_back());
            end
            m_pc = nxt;
        end
        @(negedge clk);
        check(tag, pc_q, m_pc);
        check(tag, stk_err, m_err);
    endtask

    task automatic set_in(bit st, int k, int c, int tgt, int len);
        step = st; kind = 3'(k); cond = 4'(c); target = 12'(tgt); cur_len = 3'(len);
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL R13 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; step = 0; kind = 0; cond = 0; flags = 0; operand = 0;
        bit_sel = 0; target = 0; offset = 0; cur_len = 1; skip_n = 0; skip_lens = 0;
        m_pc = 48; m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", pc_q, 48);
        check("R1", stk_err, 0);

        // R2 sequential, including unused kind codes
        set_in(1, 0, 0, 0, 5);   cyc("R2");
        set_in(1, 7, 0, 0, 2);   cyc("R2");
        set_in(1, 6, 0, 0, 1);   cyc("R2");
        // R13 no step holds
        set_in(0, 1, 0, 100, 3); cyc("R13");
        set_in(0, 4, 0, 200, 3); cyc("R13");
        // R3 jump to top of space
        set_in(1, 1, 0, 4095, 1); cyc("R3");
        // R4 forward wrap past 4095, then backward past 0
        set_in(1, 2, 0, 0, 2); offset = 8'h05; cyc("R4");
        set_in(1, 2, 0, 0, 2); offset = 8'h80; cyc("R4");
        set_in(1, 2, 0, 0, 1); offset = 8'h7F; cyc("R4");
        // R5 skips of every count
        for (int n = 0; n < 4; n++) begin
            set_in(1, 3, 0, 0, 4); skip_n = 2'(n); skip_lens = {3'd5, 3'd3, 3'd1};
            cyc("R5");
        end
        // R6 flag conditions over every flag pattern, R8 when failing
        for (int c = 1; c <= 8; c++) begin
            for (int f = 0; f < 16; f++) begin
                set_in(1, 1, c, 600 + c * 16 + f, 1); flags = 4'(f);
                cyc(cond_holds() ? "R6" : "R8");
            end
        end
        set_in(1, 1, 13, 77, 1); flags = 4'hF; cyc("R6");
        // R7 bit tests
        operand = 24'h800001;
        set_in(1, 1, 9, 300, 1); bit_sel = 5'd23; cyc("R7");
        set_in(1, 1, 9, 310, 1); bit_sel = 5'd0;  cyc("R7");
        set_in(1, 1, 10, 320, 1); bit_sel = 5'd1; cyc("R7");
        operand = 24'hFFFFFF;
        set_in(1, 1, 9, 330, 1); bit_sel = 5'd24; cyc("R7");
        set_in(1, 2, 10, 0, 1); bit_sel = 5'd31; offset = 8'hF0; cyc("R7");
        // R11 return with empty stack
        set_in(1, 5, 0, 0, 1); cyc("R11");
        // R9 calls ignore the condition; fill then overflow (R12)
        flags = 4'h0;
        for (int i = 0; i < 4; i++) begin
            set_in(1, 4, 15, 1000 + i * 100, 3); cyc("R9");
        end
        set_in(1, 4, 3, 2000, 2); cyc("R12");
        set_in(1, 0, 0, 0, 1); cyc("R12");
        // R10 drain in LIFO order, then underflow
        for (int i = 0; i < 4; i++) begin
            set_in(1, 5, 0, 0, 1); cyc("R10");
        end
        set_in(1, 5, 0, 0, 1); cyc("R11");

        // Mixed random stream against the model
        void'($urandom(17));
        for (int i = 0; i < 3000; i++) begin
            step      = ($urandom_range(0, 9) < 8);
            kind      = 3'($urandom_range(0, 7));
            cond      = 4'($urandom_range(0, 15));
            flags     = 4'($urandom);
            operand   = 24'($urandom);
            bit_sel   = 5'($urandom);
            target    = 12'($urandom);
            offset    = 8'($urandom);
            cur_len   = 3'($urandom_range(1, 5));
            skip_n    = 2'($urandom);
            skip_lens = {3'($urandom_range(1, 5)), 3'($urandom_range(1, 5)), 3'($urandom_range(1, 5))};
            case (kind)
                3'd1: cyc("R3");
                3'd2: cyc("R4");
                3'd3: cyc("R5");
                3'd4: cyc("R9");
                3'd5: cyc("R10");
                default: cyc("R2");
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule